// File: doc/BRIEF.md
# Overwriting Receive Ring Buffer

This block sits behind a serial receiver and keeps every character it produces in a circular store. The store needs no attention from the consumer while it fills. The receiver presents one byte per cycle with a valid strobe. A consumer reads the store through a pop strobe and gets the byte one cycle later. It can also see the current fill level and the empty and full flags.

When the store is full, fresh data is kept and old data is given up. The oldest stored byte is thrown away, the new one is written, and a one-cycle overrun pulse is raised. One slot is always left unused, so a store of `DEPTH` slots holds at most `DEPTH-1` bytes.

A second consumer path, the direct request, asks for a fixed number of bytes. A request first takes bytes already waiting in the store, one per cycle and oldest first. After that, bytes arriving from the receiver go straight to the request output without entering the store. A done pulse marks the last byte, and from then on new bytes go into the store again. Arrival order is kept across the whole sequence.

Top module: `rx_ring_ovw`

## Requirements
- R1: A synchronous active-high reset empties the store (level 0, `empty` 1, `full` 0) and clears the pending request count, `req_busy`, `overrun`, `pop_valid`, `req_valid` and `req_done`.
- R2: Popped bytes leave in arrival order. `pop_valid` and `pop_data` appear in the cycle after the pop, and the read and write positions wrap to slot 0 after slot `DEPTH-1`.
- R3: `level` equals the number of stored bytes and never exceeds `DEPTH-1`. `full` is 1 exactly when `level` is `DEPTH-1`, and `empty` is 1 exactly when `level` is 0.
- R4: A byte that arrives while the store is full and not being popped causes three things: the oldest byte is discarded, the new byte is stored, and `overrun` pulses for one cycle with `level` held at `DEPTH-1`.
- R5: When a push and a pop happen in the same cycle on a non-empty store, `level` stays the same, and there is no overrun even if the store is full.
- R6: A pop while the store is empty has no effect: `pop_valid` stays 0 and `level` stays 0.
- R7: A `req_start` with a non-zero `req_len` on an empty store sends each following received byte to `req_data` with `req_valid`, one cycle after arrival, and lowers `req_remaining` by one per byte. Bytes sent this way do not enter the store.
- R8: A new request first takes bytes already in the store, one per cycle and oldest first. Bytes arriving meanwhile are appended to the store, and only the shortfall is served directly from the receiver.
- R9: `req_done` pulses together with the request's last byte, and `req_busy` then falls. Bytes received after that go into the store.
- R10: While a request is pending, consumer pops are ignored and a further `req_start` leaves the pending count unchanged. A `req_start` with `req_len` 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | DATA_W | Received byte |
| pop | input | 1 | Consumer read strobe |
| pop_valid | output | 1 | Popped byte valid (one cycle after `pop`) |
| pop_data | output | DATA_W | Popped byte |
| level | output | PTR_W+1 | Number of stored bytes |
| empty | output | 1 | Store holds no byte |
| full | output | 1 | Store holds DEPTH-1 bytes |
| overrun | output | 1 | One-cycle pulse: oldest byte discarded |
| req_start | input | 1 | Start a direct request |
| req_len | input | REQ_W | Bytes wanted by the request |
| req_busy | output | 1 | Request has bytes outstanding |
| req_remaining | output | REQ_W | Bytes still owed to the request |
| req_valid | output | 1 | Request byte valid |
| req_data | output | DATA_W | Request byte |
| req_done | output | 1 | Pulse with the request's final byte |

## Verification
The properties check a set of rules on every cycle. The fill level never passes its cap. An overrun appears only after an unpopped push into a full store, and the store stays full after it. A push paired with a pop leaves the level unchanged. Pops on an empty store, or while a request is pending, never produce a byte. Request bytes and the done pulse come only while a request is outstanding.

Other behaviours can only be shown by the bench's scenarios, because they need the data values themselves. These include which byte the overrun discards, the exact order in which stored bytes and bypassed bytes reach the request output, and bytes returning to the store after done.

// File: rtl/orb_pkg.sv
package orb_pkg;
  // source of the byte presented on the request output
  typedef enum logic {
    SRC_STORE  = 1'b0,
    SRC_DIRECT = 1'b1
  } orb_src_e;
endpackage

// File: rtl/orb_ptr.sv
module orb_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (adv)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/orb_store.sv
module orb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/rx_ring_ovw.sv
module rx_ring_ovw
  import orb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int REQ_W  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pop,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic [PTR_W:0]    level,
  output logic              empty,
  output logic              full,
  output logic              overrun,
  input  logic              req_start,
  input  logic [REQ_W-1:0]  req_len,
  output logic              req_busy,
  output logic [REQ_W-1:0]  req_remaining,
  output logic              req_valid,
  output logic [DATA_W-1:0] req_data,
  output logic              req_done
);
  localparam logic [PTR_W:0] CAP  = (PTR_W+1)'(DEPTH - 1);
  localparam logic [PTR_W:0] SPAN = (PTR_W+1)'(DEPTH);

  logic [PTR_W-1:0]  head, tail;
  logic [DATA_W-1:0] rd_q, byp_q;
  logic [REQ_W-1:0]  rem_q;
  orb_src_e          src_q;

  logic busy, drain, bypass, deliver, pop_ok, rd_adv, push, drop, start_ok;

  // fill level from the two positions (compare, no modulo)
  always_comb begin
    if (head >= tail)
      level = {1'b0, head} - {1'b0, tail};
    else
      level = {1'b0, head} + SPAN - {1'b0, tail};
  end

  assign empty = (level == '0);
  assign full  = (level == CAP);

  // request has priority over consumer pops and over storing
  always_comb begin
    busy     = (rem_q != '0);
    drain    = busy && !empty;
    bypass   = busy && empty && in_valid;
    deliver  = drain || bypass;
    pop_ok   = !busy && pop && !empty;
    rd_adv   = drain || pop_ok;
    push     = in_valid && !bypass;
    drop     = push && full && !rd_adv;
    start_ok = req_start && !busy && (req_len != '0);
  end

  orb_ptr #(.DEPTH(DEPTH)) u_head (
    .clk(clk), .rst(rst), .adv(push), .ptr(head)
  );

  orb_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst(rst), .adv(rd_adv || drop), .ptr(tail)
  );

  orb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(head), .wdata(in_data),
    .re(rd_adv), .raddr(tail), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q     <= '0;
      pop_valid <= 1'b0;
      req_valid <= 1'b0;
      req_done  <= 1'b0;
      overrun   <= 1'b0;
      src_q     <= SRC_STORE;
    end else begin
      if (start_ok)
        rem_q <= req_len;
      else if (deliver)
        rem_q <= rem_q - 1'b1;
      pop_valid <= pop_ok;
      req_valid <= deliver;
      req_done  <= deliver && (rem_q == REQ_W'(1));
      overrun   <= drop;
      src_q     <= bypass ? SRC_DIRECT : SRC_STORE;
    end
  end

  always_ff @(posedge clk) begin
    if (bypass)
      byp_q <= in_data;
  end

  assign pop_data      = rd_q;
  assign req_data      = (src_q == SRC_DIRECT) ? byp_q : rd_q;
  assign req_busy      = busy;
  assign req_remaining = rem_q;
endmodule

// File: rtl/rx_ring_ovw_chk.sv
module rx_ring_ovw_chk #(
  parameter int DEPTH = 8,
  parameter int REQ_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             pop,
  input logic             pop_valid,
  input logic [PTR_W:0]   level,
  input logic             empty,
  input logic             full,
  input logic             overrun,
  input logic             req_busy,
  input logic [REQ_W-1:0] req_remaining,
  input logic             req_valid,
  input logic             req_done
);
  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    level <= (PTR_W+1)'(DEPTH - 1));

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R4
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(full && in_valid && !pop && !req_busy));

  // R4
  ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> full);

  // R5
  pushpop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pop && !empty && !req_busy) |=> ($stable(level) && !overrun));

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !req_busy) |=> !pop_valid);

  // R10
  busy_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    req_busy |=> !pop_valid);

  // R7
  req_out_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(req_busy));

  // R9
  done_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (req_valid && !req_busy && req_remaining == '0));
endmodule

bind rx_ring_ovw rx_ring_ovw_chk #(.DEPTH(DEPTH), .REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pop(pop),
  .pop_valid(pop_valid), .level(level), .empty(empty), .full(full),
  .overrun(overrun), .req_busy(req_busy), .req_remaining(req_remaining),
  .req_valid(req_valid), .req_done(req_done)
);

// File: tb/sim_rx_ring_ovw.sv
`timescale 1ns/1ps
module sim_rx_ring_ovw;
  localparam int DW = 8;
  localparam int DP = 8;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          pop = 1'b0;
  logic          pop_valid;
  logic [DW-1:0] pop_data;
  logic [3:0]    level;
  logic          empty, full, overrun;
  logic          req_start = 1'b0;
  logic [RW-1:0] req_len = '0;
  logic          req_busy;
  logic [RW-1:0] req_remaining;
  logic          req_valid;
  logic [DW-1:0] req_data;
  logic          req_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rx_ring_ovw #(.DATA_W(DW), .DEPTH(DP), .REQ_W(RW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .pop(pop),
    .pop_valid(pop_valid), .pop_data(pop_data), .level(level), .empty(empty),
    .full(full), .overrun(overrun), .req_start(req_start), .req_len(req_len),
    .req_busy(req_busy), .req_remaining(req_remaining), .req_valid(req_valid),
    .req_data(req_data), .req_done(req_done)
  );

  // {in_valid, in_data, pop, exp_level, exp_pop_valid, exp_pop_data, exp_overrun}
  localparam logic [23:0] VEC [22] = '{
    {1'b1, 8'h11, 1'b0, 4'd1, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h22, 1'b0, 4'd2, 1'b0, 8'h00, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd1, 1'b1, 8'h11, 1'b0},
    {1'b1, 8'h33, 1'b1, 4'd1, 1'b1, 8'h22, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd0, 1'b1, 8'h33, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd0, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h40, 1'b0, 4'd1, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h41, 1'b0, 4'd2, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h42, 1'b0, 4'd3, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h43, 1'b0, 4'd4, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h44, 1'b0, 4'd5, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h45, 1'b0, 4'd6, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h46, 1'b0, 4'd7, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h47, 1'b0, 4'd7, 1'b0, 8'h00, 1'b1},
    {1'b1, 8'h48, 1'b1, 4'd7, 1'b1, 8'h41, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd6, 1'b1, 8'h42, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd5, 1'b1, 8'h43, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd4, 1'b1, 8'h44, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd3, 1'b1, 8'h45, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd2, 1'b1, 8'h46, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd1, 1'b1, 8'h47, 1'b0},
    {1'b0, 8'h00, 1'b1, 4'd0, 1'b1, 8'h48, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_data = '0; pop = 1'b0; req_start = 1'b0; req_len = '0;
  endtask

  task automatic push(input logic [7:0] d);
    idle(); in_valid = 1'b1; in_data = d; tick();
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 level", 32'(level), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 busy", 32'(req_busy), 0);
    chk("R1 overrun", 32'(overrun), 0);

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < 22; i++) begin
      logic [23:0] v;
      v = VEC[i];
      idle();
      in_valid = v[23]; in_data = v[22:15]; pop = v[14];
      tick();
      chk("R3 level", 32'(level), 32'(v[13:10]));
      chk("R3 full", 32'(full), 32'(v[13:10] == 4'd7));
      chk("R3 empty", 32'(empty), 32'(v[13:10] == 4'd0));
      chk("R2/R6 pop_valid", 32'(pop_valid), 32'(v[9]));
      if (v[9]) chk("R2 pop_data", 32'(pop_data), 32'(v[8:1]));
      chk("R4/R5 overrun", 32'(overrun), 32'(v[0]));
    end

    // R7 request on empty store, R9 done
    idle(); req_start = 1'b1; req_len = 8'd3; tick();
    chk("R7 busy", 32'(req_busy), 1);
    chk("R7 remaining", 32'(req_remaining), 3);
    push(8'hA1);
    chk("R7 valid", 32'(req_valid), 1);
    chk("R7 data", 32'(req_data), 32'hA1);
    chk("R7 level", 32'(level), 0);
    chk("R7 remaining", 32'(req_remaining), 2);
    push(8'hA2);
    chk("R7 data", 32'(req_data), 32'hA2);
    push(8'hA3);
    chk("R9 data", 32'(req_data), 32'hA3);
    chk("R9 done", 32'(req_done), 1);
    chk("R9 busy", 32'(req_busy), 0);
    push(8'hA4);
    chk("R9 no req_valid", 32'(req_valid), 0);
    chk("R9 done pulse", 32'(req_done), 0);
    chk("R9 level", 32'(level), 1);
    idle(); pop = 1'b1; tick();
    chk("R9 stored byte", 32'(pop_data), 32'hA4);

    // R8 drain-first request, R10 pops and starts ignored while busy
    push(8'hB1);
    push(8'hB2);
    idle(); req_start = 1'b1; req_len = 8'd4; tick();
    chk("R8 remaining", 32'(req_remaining), 4);
    chk("R8 level", 32'(level), 2);
    idle(); pop = 1'b1; req_start = 1'b1; req_len = 8'd9; tick();
    chk("R8 data", 32'(req_data), 32'hB1);
    chk("R8 valid", 32'(req_valid), 1);
    chk("R10 pop ignored", 32'(pop_valid), 0);
    chk("R10 start ignored", 32'(req_remaining), 3);
    push(8'hB3);
    chk("R8 data", 32'(req_data), 32'hB2);
    chk("R8 level", 32'(level), 1);
    idle(); tick();
    chk("R8 data", 32'(req_data), 32'hB3);
    chk("R8 level", 32'(level), 0);
    chk("R8 remaining", 32'(req_remaining), 1);
    push(8'hB4);
    chk("R8 bypass data", 32'(req_data), 32'hB4);
    chk("R9 done", 32'(req_done), 1);
    idle(); tick();
    chk("R9 valid low", 32'(req_valid), 0);

    // R10 zero-length start
    idle(); req_start = 1'b1; req_len = 8'd0; tick();
    chk("R10 zero len", 32'(req_busy), 0);
    push(8'hC1);
    chk("R10 zero len stores", 32'(level), 1);

    // R1 reset mid-operation
    push(8'hC2);
    idle(); req_start = 1'b1; req_len = 8'd5; rst = 1'b1; tick();
    rst = 1'b0; idle(); tick();
    chk("R1 level after reset", 32'(level), 0);
    chk("R1 busy after reset", 32'(req_busy), 0);
    chk("R1 empty after reset", 32'(empty), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule